// File: doc/BRIEF.md
# Bitmap File Byte-Stream Formatter

This block turns a stream of processed pixel pairs into the exact byte sequence of an uncompressed 24-bit bitmap file. The output is a byte-wide valid/ready stream. A file writer, a DMA engine or a serial link can consume it directly. No file access happens inside the block.

After reset the block emits the 54-byte file header. The image dimensions and the total file size in that header come from the `IMG_W` and `IMG_H` parameters. The block then accepts one pixel pair at a time, holds it in a small buffer and sends its six colour bytes out in file order. While the buffer is busy, the pixel input sees backpressure. A sticky completion flag rises once the last pixel byte has been taken. The image width must be a multiple of four, because no row padding is inserted.

Top module: `bmp_stream_fmt`

## Requirements
- R1: While reset is held and after it is released, the stream restarts at header byte 0. `out_valid` is 1, `out_byte` is 66, `pair_ready` is 0 and `done` is 0.
- R2: Header bytes 0 and 1 are 66 and 77 (the ASCII letters 'B' and 'M').
- R3: Header bytes 2 to 5 carry the file size 54 + IMG_W*IMG_H*3, least significant byte first.
- R4: Header byte 10 is 54, byte 14 is 40, byte 26 is 1 and byte 28 is 24. Every header byte not named in R2, R3, R4 or R5 is 0.
- R5: Header bytes 18 to 21 carry IMG_W and bytes 22 to 25 carry IMG_H, each least significant byte first.
- R6: From byte 54 on, every pixel is sent as blue, green, red. The even pixel (port group `pix0`) of a pair goes before the odd one (`pix1`). Pairs go out in the order they were accepted.
- R7: `pair_ready` is 0 during the whole header and while a buffered pair still has bytes to send. It is 1 only when the buffer is empty and the image is unfinished. Every accepted pair is emitted in full, and the block accepts exactly IMG_W*IMG_H/2 pairs.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_byte` unchanged.
- R9: `done` rises in the cycle after the clock edge that accepts byte number 54 + IMG_W*IMG_H*3 (counting from 1). It then stays 1 until reset, with `out_valid` and `pair_ready` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pair_valid | input | 1 | A pixel pair is offered (line-active qualifier) |
| pair_ready | output | 1 | The block takes the offered pair at this edge |
| pix0_b | input | 8 | Blue of the even pixel |
| pix0_g | input | 8 | Green of the even pixel |
| pix0_r | input | 8 | Red of the even pixel |
| pix1_b | input | 8 | Blue of the odd pixel |
| pix1_g | input | 8 | Green of the odd pixel |
| pix1_r | input | 8 | Red of the odd pixel |
| out_valid | output | 1 | `out_byte` holds a file byte |
| out_ready | input | 1 | The consumer takes `out_byte` at this edge |
| out_byte | output | 8 | Next byte of the file |
| done | output | 1 | The whole file has been delivered |

## Verification
The properties assume that the pixel source keeps its data stable only in the cycle of a handshake. They also assume that the consumer may withhold `out_ready` at any time. Neither side is assumed to wait for the other before raising its own signal. The stimulus raises `pair_valid` and `out_ready` at random, independently of the block's outputs, and always offers the next unsent pair. It never offers more than IMG_W*IMG_H/2 pairs. A few directed pairs cover saturated values (all 255 and all 0), and the consumer runs in three modes: always ready, mostly ready and half ready.

// File: rtl/bmpfmt_pkg.sv
package bmpfmt_pkg;

   localparam int unsigned HDR_BYTES = 54;
   localparam int unsigned INFO_SIZE = 40;
   localparam int unsigned BPP       = 24;

   typedef enum logic [1:0] {
      PH_HDR = 2'd0,
      PH_PIX = 2'd1,
      PH_END = 2'd2
   } phase_t;

   // Header byte at position idx for an image of w x h pixels.
   function automatic logic [7:0] hdr_byte(input int unsigned idx,
                                           input int unsigned w,
                                           input int unsigned h);
      logic [31:0] fsz;
      logic [31:0] word;
      logic [31:0] sh;
      fsz  = HDR_BYTES + w * h * 3;
      word = 32'd0;
      sh   = 32'd0;
      case (idx)
         0:  word = 32'd66;
         1:  word = 32'd77;
         2, 3, 4, 5: begin
            sh   = 8 * (idx - 2);
            word = fsz >> sh;
         end
         10: word = HDR_BYTES;
         14: word = INFO_SIZE;
         18, 19, 20, 21: begin
            sh   = 8 * (idx - 18);
            word = w >> sh;
         end
         22, 23, 24, 25: begin
            sh   = 8 * (idx - 22);
            word = h >> sh;
         end
         26: word = 32'd1;
         28: word = BPP;
         default: word = 32'd0;
      endcase
      return word[7:0];
   endfunction

endpackage

// File: rtl/bmp_hdr_gen.sv
module bmp_hdr_gen
   import bmpfmt_pkg::*;
#(
   parameter int unsigned IMG_W = 8,
   parameter int unsigned IMG_H = 4,
   parameter int unsigned IDX_W = 6
)(
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);

   localparam int unsigned PAD_W = 32 - IDX_W;

   always_comb begin
      byte_o = hdr_byte({{PAD_W{1'b0}}, idx}, IMG_W, IMG_H);
   end

endmodule

// File: rtl/bmp_pair_ser.sv
module bmp_pair_ser #(
   parameter int unsigned CH_W = 8,
   parameter int unsigned NPIX = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      pop,
   input  logic [NPIX-1:0][CH_W-1:0] in_b,
   input  logic [NPIX-1:0][CH_W-1:0] in_g,
   input  logic [NPIX-1:0][CH_W-1:0] in_r,
   output logic                      full,
   output logic                      last,
   output logic [CH_W-1:0]           byte_o
);

   localparam int unsigned NLANE = NPIX * 3;
   localparam int unsigned SUB_W = $clog2(NLANE);

   logic [CH_W-1:0]  lane [NLANE];
   logic [SUB_W-1:0] sub;

   // Lanes in file order: per pixel blue, green, red; pixel 0 first.
   for (genvar p = 0; p < NPIX; p++) begin : g_pix
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane[3*p]   <= '0;
            lane[3*p+1] <= '0;
            lane[3*p+2] <= '0;
         end else if (load) begin
            lane[3*p]   <= in_b[p];
            lane[3*p+1] <= in_g[p];
            lane[3*p+2] <= in_r[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         sub  <= '0;
      end else if (load) begin
         full <= 1'b1;
         sub  <= '0;
      end else if (pop && full) begin
         if (last) begin
            full <= 1'b0;
            sub  <= '0;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assign last = (sub == SUB_W'(NLANE - 1));

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < NLANE; i++) begin
         if (sub == SUB_W'(i)) byte_o = lane[i];
      end
   end

endmodule

// File: rtl/bmp_seq.sv
module bmp_seq
   import bmpfmt_pkg::*;
#(
   parameter int unsigned NPAIRS = 16,
   parameter int unsigned IDX_W  = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             out_fire,
   input  logic             pair_last,
   output phase_t           phase,
   output logic [IDX_W-1:0] hdr_idx
);

   localparam int unsigned PCW = (NPAIRS > 1) ? $clog2(NPAIRS) : 1;

   logic [PCW-1:0] pair_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_HDR;
         hdr_idx  <= '0;
         pair_cnt <= '0;
      end else begin
         case (phase)
            PH_HDR: if (out_fire) begin
               if (hdr_idx == IDX_W'(HDR_BYTES - 1)) phase <= PH_PIX;
               else                                  hdr_idx <= hdr_idx + 1'b1;
            end
            PH_PIX: if (out_fire && pair_last) begin
               if (pair_cnt == PCW'(NPAIRS - 1)) phase    <= PH_END;
               else                              pair_cnt <= pair_cnt + 1'b1;
            end
            default: phase <= PH_END;
         endcase
      end
   end

endmodule

// File: rtl/bmp_stream_fmt.sv
module bmp_stream_fmt
   import bmpfmt_pkg::*;
#(
   parameter int unsigned IMG_W = 8,
   parameter int unsigned IMG_H = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pair_valid,
   output logic       pair_ready,
   input  logic [7:0] pix0_b,
   input  logic [7:0] pix0_g,
   input  logic [7:0] pix0_r,
   input  logic [7:0] pix1_b,
   input  logic [7:0] pix1_g,
   input  logic [7:0] pix1_r,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_byte,
   output logic       done
);

   localparam int unsigned NPAIRS = IMG_W * IMG_H / 2;
   localparam longint unsigned FSIZE = longint'(HDR_BYTES) + longint'(IMG_W) * IMG_H * 3;
   localparam int unsigned IDX_W  = $clog2(HDR_BYTES);

   // Elaboration-time parameter checks
   if (IMG_W == 0 || IMG_H == 0) begin : g_bad_dim
      $error("bmp_stream_fmt: image dimensions must be non-zero");
   end
   if (IMG_W % 4 != 0) begin : g_bad_pad
      $error("bmp_stream_fmt: IMG_W must be a multiple of 4 (no row padding)");
   end
   if (FSIZE > 64'hFFFF_FFFF) begin : g_bad_size
      $error("bmp_stream_fmt: file size exceeds 32-bit header field");
   end

   phase_t           phase;
   logic [IDX_W-1:0] hdr_idx;
   logic [7:0]       hdr_b;
   logic [7:0]       pix_b;
   logic             buf_full;
   logic             buf_last;
   logic             out_fire;
   logic             load;

   assign out_valid  = (phase == PH_HDR) || ((phase == PH_PIX) && buf_full);
   assign out_fire   = out_valid && out_ready;
   assign pair_ready = (phase == PH_PIX) && !buf_full;
   assign load       = pair_valid && pair_ready;
   assign out_byte   = (phase == PH_HDR) ? hdr_b : pix_b;
   assign done       = (phase == PH_END);

   bmp_seq #(
      .NPAIRS (NPAIRS),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_fire  (out_fire),
      .pair_last (buf_last),
      .phase     (phase),
      .hdr_idx   (hdr_idx)
   );

   bmp_hdr_gen #(
      .IMG_W (IMG_W),
      .IMG_H (IMG_H),
      .IDX_W (IDX_W)
   ) u_hdr (
      .idx    (hdr_idx),
      .byte_o (hdr_b)
   );

   bmp_pair_ser #(
      .CH_W (8),
      .NPIX (2)
   ) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .pop    (out_fire && (phase == PH_PIX)),
      .in_b   ({pix1_b, pix0_b}),
      .in_g   ({pix1_g, pix0_g}),
      .in_r   ({pix1_r, pix0_r}),
      .full   (buf_full),
      .last   (buf_last),
      .byte_o (pix_b)
   );

endmodule

// File: rtl/bmp_stream_fmt_chk.sv
module bmp_stream_fmt_chk #(
   parameter int unsigned IMG_W = 8,
   parameter int unsigned IMG_H = 4
)(
   input logic       clk,
   input logic       rst_n,
   input logic       pair_valid,
   input logic       pair_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_byte,
   input logic       done
);

   localparam int unsigned TOTAL = 54 + IMG_W * IMG_H * 3;
   localparam int unsigned CW    = $clog2(TOTAL + 1);

   logic [CW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      seen <= '0;
      else if (out_valid && out_ready) seen <= seen + 1'b1;
   end

   assert_magic0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen == '0) |-> out_byte == 8'd66);

   assert_magic1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen == CW'(1)) |-> out_byte == 8'd77);

   assert_no_ready_in_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen < CW'(54)) |-> !pair_ready);

   assert_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ready |-> !out_valid);

   assert_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid && pair_ready) |=> out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

   assert_done_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> seen == CW'(TOTAL));

   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!out_valid && !pair_ready));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

endmodule

bind bmp_stream_fmt bmp_stream_fmt_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pair_valid (pair_valid),
   .pair_ready (pair_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_byte   (out_byte),
   .done       (done)
);

// File: tb/tb_bmp_stream_fmt.sv
`timescale 1ns/1ps
module tb_bmp_stream_fmt;

   localparam int W     = 8;
   localparam int H     = 4;
   localparam int NP    = W * H / 2;
   localparam int TOTAL = 54 + W * H * 3;
   localparam int WD    = 50000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pair_valid = 1'b0;
   logic       pair_ready;
   logic [7:0] pix0_b = '0, pix0_g = '0, pix0_r = '0;
   logic [7:0] pix1_b = '0, pix1_g = '0, pix1_r = '0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_byte;
   logic       done;

   logic [7:0] pd [NP][6];
   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   bmp_stream_fmt #(.IMG_W(W), .IMG_H(H)) dut (.*);

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [7:0] le_of(input int v, input int pos);
      return 8'((v / (1 << (8 * pos))) % 256);
   endfunction

   function automatic logic [7:0] exp_byte(input int k);
      int fsz;
      int p;
      fsz = 54 + W * H * 3;
      if (k < 54) begin
         if (k == 0)                 return 8'd66;
         if (k == 1)                 return 8'd77;
         if (k >= 2 && k <= 5)       return le_of(fsz, k - 2);
         if (k >= 18 && k <= 21)     return le_of(W, k - 18);
         if (k >= 22 && k <= 25)     return le_of(H, k - 22);
         if (k == 10)                return 8'd54;
         if (k == 14)                return 8'd40;
         if (k == 26)                return 8'd1;
         if (k == 28)                return 8'd24;
         return 8'd0;
      end
      p = k - 54;
      // pixel p/3, channel p%3 (0 blue, 1 green, 2 red); pair = pixel/2
      return pd[(p / 3) / 2][((p / 3) % 2) * 3 + (p % 3)];
   endfunction

   function automatic string tag_of(input int k);
      if (k < 2)                          return "R2";
      if (k <= 5)                         return "R3";
      if (k >= 18 && k <= 25)             return "R5";
      if (k < 54)                         return "R4";
      return "R6";
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      pair_valid = 1'b0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b1 && out_byte == 8'd66 && pair_ready == 1'b0 && done == 1'b0,
          "R1 in reset", {out_valid, pair_ready, done, out_byte}, {3'b100, 8'd66});
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(out_valid == 1'b1 && out_byte == 8'd66 && pair_ready == 1'b0 && done == 1'b0,
          "R1 after release", {out_valid, pair_ready, done, out_byte}, {3'b100, 8'd66});
   endtask

   task automatic run_stream(input int stop_after, input int mode);
      int bidx = 0;
      int pidx = 0;
      logic prev_stall = 1'b0;
      logic [7:0] prev_byte = '0;
      while (bidx < stop_after) begin
         @(negedge clk);
         cyc++;
         if (cyc > WD) begin
            chk(1'b0, "watchdog", cyc, WD);
            break;
         end
         case (mode)
            0:       out_ready = 1'b1;
            1:       out_ready = ($urandom % 4) != 0;
            default: out_ready = ($urandom % 2) != 0;
         endcase
         pair_valid = (pidx < NP) && (($urandom % 3) != 0);
         if (pidx < NP) begin
            pix0_b = pd[pidx][0]; pix0_g = pd[pidx][1]; pix0_r = pd[pidx][2];
            pix1_b = pd[pidx][3]; pix1_g = pd[pidx][4]; pix1_r = pd[pidx][5];
         end
         #1;
         if (bidx < 54 && pair_ready) chk(1'b0, "R7 ready in header", 1, 0);
         if (out_valid && pair_ready) chk(1'b0, "R7 ready while busy", 1, 0);
         if (done) chk(1'b0, "R9 early done", bidx, TOTAL);
         if (prev_stall)
            chk(out_valid && out_byte == prev_byte, "R8 hold", out_byte, prev_byte);
         if (out_valid && out_ready) begin
            chk(out_byte == exp_byte(bidx), tag_of(bidx), out_byte, exp_byte(bidx));
            bidx++;
         end
         if (pair_valid && pair_ready) pidx++;
         prev_stall = out_valid && !out_ready;
         prev_byte  = out_byte;
      end
      if (stop_after == TOTAL) begin
         chk(pidx == NP, "R7 pairs accepted", pidx, NP);
         @(negedge clk);
         pair_valid = 1'b1;
         out_ready = 1'b1;
         #1;
         chk(done == 1'b1, "R9 done raised", done, 1);
         chk(out_valid == 1'b0 && pair_ready == 1'b0, "R9 quiet after done",
             {out_valid, pair_ready}, 0);
         repeat (3) @(negedge clk);
         #1;
         chk(done == 1'b1 && out_valid == 1'b0, "R9 done sticky", {done, out_valid}, 2);
         pair_valid = 1'b0;
      end
   endtask

   initial begin
      int unsigned seed_val;
      seed_val = $urandom(32'd20240611);
      for (int i = 0; i < NP; i++)
         for (int j = 0; j < 6; j++)
            pd[i][j] = 8'($urandom);
      // directed corners: saturated pairs and a walking pattern
      for (int j = 0; j < 6; j++) begin
         pd[0][j]      = 8'hFF;
         pd[NP-1][j]   = 8'h00;
         pd[1][j]      = 8'(8'h10 * (j + 1));
      end

      do_reset();
      run_stream(70, 1);          // partial image, then reset mid-stream
      do_reset();                 // R1 restart from header byte 0
      run_stream(TOTAL, 1);
      do_reset();
      run_stream(TOTAL, 2);
      do_reset();
      run_stream(TOTAL, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule